// File: doc/BRIEF.md
# Datapath Self-Test Sequencer

This block exercises the digital datapath that sits behind a two-channel converter. On command it replaces the converter words at the head of the path with words from a pseudorandom source for a fixed number of sample cycles. The datapath output is not gated, so the injected sequence stays visible downstream while the test runs. The block compresses the words leaving the tail of the path into a 16-bit signature and compares the result with a constant that is fixed at build time. It then reports pass or fail and keeps the raw signature readable, so a fail can still be examined by hand.

Control is through a small byte-wide register port. The control byte has an enable bit that starts a run and an init bit that chooses between reloading the pseudorandom source and continuing from where it stopped. The run is handled by a five-state sequencer. `ST_IDLE` moves to `ST_PRIME` on start. `ST_PRIME` injects words while the path fills and moves to `ST_STREAM` after `PATH_LAT` cycles. `ST_STREAM` injects and compresses at the same time, and moves to `ST_FLUSH` once the last word has been injected. `ST_FLUSH` compresses only, draining the path, and moves to `ST_JUDGE` after `PATH_LAT` cycles. `ST_JUDGE` latches done and pass and always returns to `ST_IDLE`.

Top module: `dpath_bist`

## Requirements
- R1: While no run is active, `head_data` equals `conv_data` in every cycle.
- R2: A run starts when a write to address 0x0E has bit 0 set while idle. If bit 2 of that write is also set, the source reloads an all-ones 23-bit register. Otherwise it continues from its previous state. Each injected cycle presents the low 16 register bits as `head_data`, with channel 0 in bits 7:0. The register then shifts left once, and the new bit 0 is the XOR of bits 22 and 17.
- R3: Injection lasts exactly `RUN_LEN` (512) cycles, starting in the cycle after the start edge. After that, `head_data` returns to `conv_data`. Bit 0 of address 0x0E reads 1 while a run is active and clears itself when the run ends.
- R4: The signature is cleared at start. It then folds in the `RUN_LEN` words that appear on `tail_data` from `PATH_LAT` cycles after the start onward. Each fold is sig = (sig<<1) ^ (sig[15] ? 0x1021 : 0) ^ word. Pass is set when the final signature equals `EXP_SIG`.
- R5: The signature reads back with its low byte at address 0x24 and its high byte at address 0x25.
- R6: A run started with bit 2 clear continues the source sequence. Its signature is that of the continued words, so it reports a fail.
- R7: Address 0x0E reads {pass, done, 0, 0, 0, init, 0, enable} from bit 7 down to bit 0. Done and pass clear at start, are set at completion, and hold until the next start.
- R8: Writes to address 0x0E while a run is active are ignored. This includes a write that lands on the judging cycle. Such a write neither restarts the run, changes init, nor stops the run.
- R9: A single corrupted word on `tail_data` inside the compression window makes the run report a fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| conv_data | input | NCH*W | Converter words, channel 0 in the low byte |
| head_data | output | NCH*W | Words driven into the head of the datapath |
| tail_data | input | NCH*W | Words leaving the tail of the datapath |

## Verification
Two events can fall in the same cycle: a start command and the completion of the previous run. The bench counts edges from a start and times a new write of 0x05 so that it is sampled exactly on the edge that leaves `ST_JUDGE`. It then expects the finished run's done and pass to be set with enable clear, and `head_data` to follow `conv_data`, which shows that no second injection began. A second overlap is a register write that lands in the middle of injection. The scoreboard must still see an unbroken pseudorandom sequence of full length after that write.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIME,
        ST_STREAM,
        ST_FLUSH,
        ST_JUDGE
    } seq_state_t;

    localparam int          SIG_W    = 16;
    localparam logic [15:0] SIG_POLY = 16'h1021;

    localparam logic [7:0] ADDR_CTRL   = 8'h0E;
    localparam logic [7:0] ADDR_SIG_LO = 8'h24;
    localparam logic [7:0] ADDR_SIG_HI = 8'h25;

    localparam int BIT_EN   = 0;
    localparam int BIT_INIT = 2;
    localparam int BIT_DONE = 6;
    localparam int BIT_PASS = 7;

endpackage

// File: rtl/dpb_pn_src.sv
module dpb_pn_src #(
    parameter int               PN_LEN = 23,
    parameter int               PN_TAP = 18,
    parameter int               OUT_W  = 16,
    parameter logic [PN_LEN-1:0] SEED  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reseed,
    input  logic             step,
    output logic [OUT_W-1:0] word
);

    logic [PN_LEN-1:0] lfsr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else if (reseed) begin
            lfsr_q <= SEED;
        end else if (step) begin
            lfsr_q <= {lfsr_q[PN_LEN-2:0], lfsr_q[PN_LEN-1] ^ lfsr_q[PN_TAP-1]};
        end
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < OUT_W; i++) begin
            word[i] = lfsr_q[i % PN_LEN];
        end
    end

    // R2: the source only moves when stepped or reloaded
    assert_pn_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reseed && !step) |=> $stable(lfsr_q));

    // R2: a reload lands the seed
    assert_pn_reseed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reseed |=> (lfsr_q == SEED));

endmodule

// File: rtl/dpb_misr.sv
module dpb_misr #(
    parameter int              SIG_W = 16,
    parameter int              IN_W  = 16,
    parameter logic [SIG_W-1:0] POLY = 16'h1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             fold,
    input  logic [IN_W-1:0]  din,
    output logic [SIG_W-1:0] sig
);

    logic [SIG_W-1:0] sig_q;
    logic [SIG_W-1:0] din_x;
    logic [SIG_W-1:0] sig_d;

    // Wider inputs wrap onto the signature width by XOR
    always_comb begin
        din_x = '0;
        for (int i = 0; i < IN_W; i++) begin
            din_x[i % SIG_W] = din_x[i % SIG_W] ^ din[i];
        end
    end

    always_comb begin
        sig_d = {sig_q[SIG_W-2:0], 1'b0} ^ (sig_q[SIG_W-1] ? POLY : '0) ^ din_x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= '0;
        end else if (clear) begin
            sig_q <= '0;
        end else if (fold) begin
            sig_q <= sig_d;
        end
    end

    assign sig = sig_q;

    // R4: signature starts from zero at each run
    assert_sig_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sig_q == '0));

    // R4: signature is frozen outside the compression window
    assert_sig_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !fold) |=> $stable(sig_q));

endmodule

// File: rtl/dpb_seq.sv
module dpb_seq
    import dpb_pkg::*;
#(
    parameter int               RUN_LEN  = 512,
    parameter int               PATH_LAT = 4,
    parameter logic [SIG_W-1:0] EXP_SIG  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_start,
    input  logic [SIG_W-1:0] sig,
    output logic             start,
    output logic             busy,
    output logic             inject,
    output logic             compress,
    output logic             done,
    output logic             pass
);

    localparam int LAST   = RUN_LEN + PATH_LAT - 1;
    localparam int CNT_W  = $clog2(LAST + 2);
    localparam logic [CNT_W-1:0] C_PRIME_END  = CNT_W'(PATH_LAT - 1);
    localparam logic [CNT_W-1:0] C_STREAM_END = CNT_W'(RUN_LEN - 1);
    localparam logic [CNT_W-1:0] C_FLUSH_END  = CNT_W'(LAST);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cyc_q;
    logic             done_q, pass_q;
    logic             judge;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_start)              state_d = ST_PRIME;
            ST_PRIME:  if (cyc_q == C_PRIME_END)   state_d = ST_STREAM;
            ST_STREAM: if (cyc_q == C_STREAM_END)  state_d = ST_FLUSH;
            ST_FLUSH:  if (cyc_q == C_FLUSH_END)   state_d = ST_JUDGE;
            ST_JUDGE:                              state_d = ST_IDLE;
            default:                               state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        start    = 1'b0;
        busy     = 1'b1;
        inject   = 1'b0;
        compress = 1'b0;
        judge    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy  = 1'b0;
                start = req_start;
            end
            ST_PRIME:  inject = 1'b1;
            ST_STREAM: begin
                inject   = 1'b1;
                compress = 1'b1;
            end
            ST_FLUSH:  compress = 1'b1;
            ST_JUDGE:  judge = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // Cycle counter since start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (start) begin
            cyc_q <= '0;
        end else if (inject || compress) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // Result status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
        end else if (start) begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
        end else if (judge) begin
            done_q <= 1'b1;
            pass_q <= (sig == EXP_SIG);
        end
    end

    assign done = done_q;
    assign pass = pass_q;

    // R3: the counter never runs past the drain window
    assert_cyc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (cyc_q <= CNT_W'(LAST + 1)));

    // R3: a run always ends with done raised
    assert_end_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_q);

    // R7: status holds while idle and unstarted
    assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !req_start) |=> ($stable(done_q) && $stable(pass_q)));

    // R8: a request during a run never restarts it
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && req_start) |=> (state_q != ST_PRIME));

endmodule

// File: rtl/dpath_bist.sv
module dpath_bist
    import dpb_pkg::*;
#(
    parameter int               W        = 8,
    parameter int               NCH      = 2,
    parameter int               RUN_LEN  = 512,
    parameter int               PATH_LAT = 4,
    parameter int               PN_LEN   = 23,
    parameter int               PN_TAP   = 18,
    parameter logic [PN_LEN-1:0] PN_SEED = '1,
    parameter logic [SIG_W-1:0] EXP_SIG  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        rd_addr,
    output logic [7:0]        rd_data,
    input  logic [NCH*W-1:0]  conv_data,
    output logic [NCH*W-1:0]  head_data,
    input  logic [NCH*W-1:0]  tail_data
);

    localparam int DW = NCH * W;

    logic             ctrl_hit;
    logic             req_start;
    logic             start, busy, inject, compress, done, pass;
    logic             init_q;
    logic [DW-1:0]    pn_word;
    logic [SIG_W-1:0] sig;

    assign ctrl_hit  = wr_en && (wr_addr == ADDR_CTRL);
    assign req_start = ctrl_hit && wr_data[BIT_EN];

    // Init bit latches only on writes accepted while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q <= 1'b0;
        end else if (ctrl_hit && !busy) begin
            init_q <= wr_data[BIT_INIT];
        end
    end

    dpb_seq #(
        .RUN_LEN  (RUN_LEN),
        .PATH_LAT (PATH_LAT),
        .EXP_SIG  (EXP_SIG)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_start (req_start),
        .sig       (sig),
        .start     (start),
        .busy      (busy),
        .inject    (inject),
        .compress  (compress),
        .done      (done),
        .pass      (pass)
    );

    dpb_pn_src #(
        .PN_LEN (PN_LEN),
        .PN_TAP (PN_TAP),
        .OUT_W  (DW),
        .SEED   (PN_SEED)
    ) u_pn (
        .clk    (clk),
        .rst_n  (rst_n),
        .reseed (start && wr_data[BIT_INIT]),
        .step   (inject),
        .word   (pn_word)
    );

    dpb_misr #(
        .SIG_W (SIG_W),
        .IN_W  (DW),
        .POLY  (SIG_POLY)
    ) u_misr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .fold  (compress),
        .din   (tail_data),
        .sig   (sig)
    );

    assign head_data = inject ? pn_word : conv_data;

    always_comb begin
        rd_data = 8'h00;
        unique case (rd_addr)
            ADDR_CTRL: begin
                rd_data[BIT_EN]   = busy;
                rd_data[BIT_INIT] = init_q;
                rd_data[BIT_DONE] = done;
                rd_data[BIT_PASS] = pass;
            end
            ADDR_SIG_LO: rd_data = sig[7:0];
            ADDR_SIG_HI: rd_data = sig[15:8];
            default:     rd_data = 8'h00;
        endcase
    end

    // R1: idle path carries converter data
    assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (head_data == conv_data));

    // R8: init cannot change under a running test
    assert_init_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(init_q));

endmodule

// File: tb/dpath_bist_test.sv
`timescale 1ns/100ps
module dpath_bist_test;

    localparam int          W        = 8;
    localparam int          NCH      = 2;
    localparam int          DW       = NCH * W;
    localparam int          RUN_LEN  = 512;
    localparam int          PATH_LAT = 4;
    localparam logic [22:0] SEED     = 23'h7FFFFF;

    function automatic logic [22:0] pn_next(input logic [22:0] s);
        return {s[21:0], s[22] ^ s[17]};
    endfunction

    function automatic logic [15:0] sig_fold(input logic [15:0] m, input logic [15:0] w);
        return {m[14:0], 1'b0} ^ (m[15] ? 16'h1021 : 16'h0000) ^ w;
    endfunction

    function automatic logic [15:0] calc_sig(input logic [22:0] s0);
        logic [22:0] s;
        logic [15:0] m;
        s = s0;
        m = 16'h0000;
        for (int k = 0; k < RUN_LEN; k++) begin
            m = sig_fold(m, s[15:0]);
            s = pn_next(s);
        end
        return m;
    endfunction

    localparam logic [15:0] EXP = calc_sig(SEED);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = 8'h00;
    logic [7:0]    wr_data = 8'h00;
    logic [7:0]    rd_addr = 8'h00;
    logic [7:0]    rd_data;
    logic [DW-1:0] conv_data = 16'h2C41;
    logic [DW-1:0] head_data;
    logic [DW-1:0] tail_data;
    logic [DW-1:0] dl [PATH_LAT];
    logic          fault_on = 1'b0;

    int checks = 0;
    int errors = 0;
    int wd_cnt = 0;
    logic [DW-1:0] exp_q [$];
    logic          popping = 1'b0;
    logic [22:0]   model = SEED;

    always #2 clk = ~clk;

    dpath_bist #(
        .W        (W),
        .NCH      (NCH),
        .RUN_LEN  (RUN_LEN),
        .PATH_LAT (PATH_LAT),
        .PN_SEED  (SEED),
        .EXP_SIG  (EXP)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .conv_data (conv_data),
        .head_data (head_data),
        .tail_data (tail_data)
    );

    // Datapath stand-in: pure delay line
    always @(posedge clk) begin
        dl[0] <= head_data;
        for (int i = 1; i < PATH_LAT; i++) dl[i] <= dl[i-1];
    end
    assign tail_data = dl[PATH_LAT-1] ^ (fault_on ? 16'h0001 : 16'h0000);

    // Converter stimulus moves every cycle, away from edges
    always begin
        @(posedge clk);
        #1 conv_data = conv_data + 16'h1357;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            popping <= 1'b1;
            check("R2 injected word", head_data, e);
        end else if (popping) begin
            popping <= 1'b0;
            check("R3 head back to converter after run", head_data, conv_data);
        end
    end

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        #0.5 v = rd_data;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    // Driver: start a run and push its expected head words
    task automatic start_run(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h0E; wr_data = d;
        @(posedge clk);
        if (d[2]) model = SEED;
        for (int k = 0; k < RUN_LEN; k++) begin
            exp_q.push_back(model[15:0]);
            model = pn_next(model);
        end
        #1 wr_en = 1'b0;
    endtask

    task automatic wait_done();
        logic [7:0] v;
        for (int n = 0; n < 2000; n++) begin
            rd(8'h0E, v);
            if (!v[0]) break;
        end
    endtask

    task automatic read_sig(output logic [15:0] s);
        logic [7:0] lo, hi;
        rd(8'h24, lo);
        rd(8'h25, hi);
        s = {hi, lo};
    endtask

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] s;
        logic [15:0] exp_cont;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state
        rd(8'h0E, v);  check("R7 status after reset", 16'(v), 16'h00);
        read_sig(s);   check("R5 signature after reset", s, 16'h0000);
        @(negedge clk); check("R1 idle passthrough", head_data, conv_data);
        @(negedge clk); check("R1 idle passthrough again", head_data, conv_data);

        // Run 1: reseeded, with an ignored write mid-run
        start_run(8'h05);
        repeat (100) @(posedge clk);
        wr(8'h0E, 8'h00);
        rd(8'h0E, v);  check("R8 mid-run write ignored", 16'(v), 16'h05);
        wait_done();
        rd(8'h0E, v);  check("R4 reseeded run passes", 16'(v), 16'hC4);
        read_sig(s);   check("R5 signature bytes", s, EXP);
        repeat (20) @(posedge clk);
        rd(8'h0E, v);  check("R7 status holds while idle", 16'(v), 16'hC4);

        // Run 2: continue the sequence
        exp_cont = calc_sig(model);
        start_run(8'h01);
        wait_done();
        rd(8'h0E, v);  check("R6 continued run fails", 16'(v), 16'h40);
        read_sig(s);   check("R6 continued signature", s, exp_cont);

        // Run 3: reseeded with a corrupted tail word
        start_run(8'h05);
        rd(8'h0E, v);  check("R7 status cleared at start", 16'(v), 16'h05);
        repeat (250) @(posedge clk);
        #1 fault_on = 1'b1;
        @(posedge clk);
        #1 fault_on = 1'b0;
        wait_done();
        rd(8'h0E, v);  check("R9 corrupted tail fails", 16'(v), 16'h44);
        read_sig(s);   check("R9 signature differs", 16'(s != EXP), 16'h0001);

        // Run 4: new start lands on the judging edge
        start_run(8'h05);
        repeat (RUN_LEN + PATH_LAT) @(posedge clk);
        #1 wr_en = 1'b1; wr_addr = 8'h0E; wr_data = 8'h05;
        @(posedge clk);
        #1 wr_en = 1'b0;
        rd(8'h0E, v);  check("R8 start on judge edge dropped", 16'(v), 16'hC4);
        repeat (3) @(negedge clk);
        check("R8 no second injection", head_data, conv_data);
        check("R3 scoreboard drained", 16'(exp_q.size()), 16'h0000);
        read_sig(s);   check("R4 signature after clean rerun", s, EXP);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule